// File: doc/BRIEF.md
# Byte-Stream Transmit DMA with Unaligned Start

This block moves one frame from a word-organised heap memory into a byte-wide AXI-Stream that feeds the transmit FIFO in front of an Ethernet MAC. Software supplies a start byte address and a byte count, then pulses a start strobe. The block reads 32-bit words from memory and sends their bytes one at a time. It asserts tlast with the final byte. The start address may sit at any byte offset. The first word therefore begins at the byte lane picked by the low address bits, and the final word may be consumed only in part.

Memory access shares the heap bus with the processor. The block raises a request and holds it until the arbiter grants it in a processor-idle cycle. It drops the request in the cycle after the grant, so the bus is held for exactly one read. There is a single transfer slot. `busy` reports a transfer in flight, and `done` pulses for one cycle when a transfer completes. A zero-length transfer completes at once and sends nothing.

Control is a four-state machine. IDLE waits for start. REQ holds the bus request. WAIT captures the returned word. EMIT presents bytes on the stream. The transitions are:
- IDLE to REQ on start with a nonzero length.
- REQ to WAIT on grant.
- WAIT to EMIT always.
- EMIT to REQ when the last lane of a word is accepted and bytes remain.
- EMIT to IDLE when the final byte is accepted.
- EMIT stays in EMIT on a stall or an interior lane.

Top module: `txdma_unaligned`

## Requirements
- R1: After reset `busy`, `done`, `m_tvalid` and `mem_req` are all 0.
- R2: A `cfg_start` pulse in IDLE with nonzero `cfg_len` captures `cfg_addr` and `cfg_len`, and `busy` reads 1 in the following cycle.
- R3: Each word read sets `mem_addr` to the byte address shifted right by 2. It holds `mem_req` and `mem_addr` steady until `mem_gnt`, drops `mem_req` in the cycle after the grant, and takes `mem_rdata` in the cycle after the grant.
- R4: The first byte comes from lane `cfg_addr[1:0]`, where lane k is `mem_rdata[8k+7:8k]` (little-endian).
- R5: Byte n of the stream (counting from 0) is the memory byte at address `cfg_addr+n`. The next word is fetched only after lane 3 of the current word has been accepted.
- R6: Exactly `cfg_len` beats are sent, and `m_tlast` is 1 only on beat number `cfg_len`.
- R7: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.
- R8: `busy` clears, and `done` pulses for one cycle, in the cycle after the final beat is accepted.
- R9: A `cfg_start` pulse while `busy` is 1 is ignored, and the running transfer continues unchanged.
- R10: A start with `cfg_len` of 0 sends no beat and makes no memory request. `busy` stays 0 and `done` pulses in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | ADDR_W | Start byte address |
| cfg_len | input | LEN_W | Byte count |
| cfg_start | input | 1 | Start strobe |
| busy | output | 1 | Transfer in flight |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Heap bus read request |
| mem_addr | output | ADDR_W-2 | Word address of the read |
| mem_gnt | input | 1 | Grant in a processor-idle cycle |
| mem_rdata | input | DATA_W | Read word, valid the cycle after grant |
| m_tdata | output | 8 | Stream byte |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready |
| m_tlast | output | 1 | Final byte of the frame |

## Verification
The assertions take three things for granted about the inputs. The memory returns the granted word exactly one cycle after the grant. `mem_gnt` is only of interest while a request is raised. The stream sink may drop `m_tready` at any time, since the block alone owns the hold rule. The bench memory model registers the word on a granted request and drives a junk pattern in every other cycle, so any mistimed capture would show up. Ready and grant are driven from fixed cyclic patterns that stall both sides without ever starving them, and start strobes are presented only between falling edges.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_EMIT
    } txdma_state_e;
endpackage

// File: rtl/txdma_lane_mux.sv
module txdma_lane_mux #(
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic [7:0]        byte_o
);
    logic [7:0] lanes [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lanes[g] = word_i[8*g +: 8];
    end

    assign byte_o = lanes[lane_i];
endmodule

// File: rtl/txdma_remain.sv
module txdma_remain #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             is_last
);
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (load)  cnt_q <= load_val;
        else if (dec)   cnt_q <= cnt_q - 1'b1;
    end

    assign is_last = (cnt_q == LEN_W'(1));

    // R6: never count below zero
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> cnt_q != '0);
endmodule

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
    import txdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12,
    parameter int DATA_W = 32,
    localparam int LANE_W = $clog2(DATA_W / 8),
    localparam int WA_W   = ADDR_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_start,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              tready,
    input  logic              cnt_last,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic [WA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] word_q,
    output logic [LANE_W-1:0] lane_q,
    output logic              tvalid,
    output logic              tlast,
    output logic              cnt_load,
    output logic              cnt_dec
);
    localparam logic [LANE_W-1:0] LANE_MAX = '1;

    txdma_state_e state_q, state_d;
    logic [WA_W-1:0] waddr_q;
    logic            done_q;
    logic            accept;
    logic            beat;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && cfg_len != '0) state_d = ST_REQ;
            ST_REQ:  if (mem_gnt)                 state_d = ST_WAIT;
            ST_WAIT:                              state_d = ST_EMIT;
            ST_EMIT: begin
                if (beat) begin
                    if (cnt_last)               state_d = ST_IDLE;
                    else if (lane_q == LANE_MAX) state_d = ST_REQ;
                end
            end
            default:                              state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept   = cfg_start && (state_q == ST_IDLE);
        mem_req  = (state_q == ST_REQ);
        tvalid   = (state_q == ST_EMIT);
        tlast    = tvalid && cnt_last;
        busy     = (state_q != ST_IDLE);
        beat     = tvalid && tready;
        cnt_load = accept;
        cnt_dec  = beat;
        mem_addr = waddr_q;
        done     = done_q;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr_q <= '0;
            lane_q  <= '0;
            word_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (accept && cfg_len == '0) || (beat && cnt_last);
            if (accept) begin
                waddr_q <= cfg_addr[ADDR_W-1:LANE_W];
                lane_q  <= cfg_addr[LANE_W-1:0];
            end
            if (state_q == ST_WAIT) word_q <= mem_rdata;
            if (beat && !cnt_last) begin
                if (lane_q == LANE_MAX) begin
                    lane_q  <= '0;
                    waddr_q <= waddr_q + 1'b1;
                end else begin
                    lane_q <= lane_q + 1'b1;
                end
            end
        end
    end

    // R3: bus released right after the granted read
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_gnt |=> !mem_req);
    // R3: request and address held until granted
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));
    // R8: busy only falls after the last beat is taken
    a_r8_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tvalid && tready && tlast));
    // R9: a start while busy does not end the transfer
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cfg_start && !(tvalid && tready && tlast) |=> busy);
    // R10: zero length finishes at once without going busy
    a_r10_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && cfg_start && cfg_len == '0 |=> !busy && done);
endmodule

// File: rtl/txdma_unaligned.sv
module txdma_unaligned #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12,
    parameter int DATA_W = 32,
    localparam int LANE_W = $clog2(DATA_W / 8),
    localparam int WA_W   = ADDR_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_start,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic [WA_W-1:0]   mem_addr,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [7:0]        m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tlast
);
    logic [DATA_W-1:0] word_q;
    logic [LANE_W-1:0] lane_q;
    logic              cnt_last;
    logic              cnt_load;
    logic              cnt_dec;

    txdma_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_addr (cfg_addr),
        .cfg_len  (cfg_len),
        .cfg_start(cfg_start),
        .mem_gnt  (mem_gnt),
        .mem_rdata(mem_rdata),
        .tready   (m_tready),
        .cnt_last (cnt_last),
        .busy     (busy),
        .done     (done),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .word_q   (word_q),
        .lane_q   (lane_q),
        .tvalid   (m_tvalid),
        .tlast    (m_tlast),
        .cnt_load (cnt_load),
        .cnt_dec  (cnt_dec)
    );

    txdma_remain #(.LEN_W(LEN_W)) u_remain (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cfg_len),
        .dec     (cnt_dec),
        .is_last (cnt_last)
    );

    txdma_lane_mux #(.DATA_W(DATA_W)) u_mux (
        .word_i(word_q),
        .lane_i(lane_q),
        .byte_o(m_tdata)
    );

    // R7: stream held stable while stalled
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));
    // R5: no byte is offered while the bus is being requested
    a_r5_fetch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && m_tvalid));
endmodule

// File: tb/txdma_unaligned_test.sv
`timescale 1ns/1ps
module txdma_unaligned_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cfg_addr;
    logic [11:0] cfg_len;
    logic        cfg_start;
    logic        busy, done, mem_req, mem_gnt;
    logic [13:0] mem_addr;
    logic [31:0] mem_rdata;
    logic [7:0]  m_tdata;
    logic        m_tvalid, m_tready, m_tlast;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    txdma_unaligned uut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_len(cfg_len),
        .cfg_start(cfg_start), .busy(busy), .done(done), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tlast(m_tlast)
    );

    function automatic logic [7:0] mbyte(input int a);
        return 8'((a * 5 + 17) & 255);
    endfunction

    // heap model: word registered on a granted request, junk otherwise
    always @(posedge clk) begin
        if (mem_req && mem_gnt) begin
            for (int b = 0; b < 4; b++)
                mem_rdata[8*b +: 8] <= mbyte(int'(mem_addr) * 4 + b);
        end else begin
            mem_rdata <= 32'hDEAD_BEEF;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one transfer; rmode/gmode pick ready/grant patterns; poke issues start mid-run
    task automatic run_xfer(input int a, input int l, input int rmode, input int gmode,
                            input bit poke);
        int  n = 0;
        bit  fin = 0;
        bit  stalled = 0;
        int  sdata = 0;
        @(negedge clk);
        cfg_addr  = 16'(a);
        cfg_len   = 12'(l);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        cfg_addr  = 16'h0123;
        cfg_len   = 12'd3;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        for (int cyc = 0; cyc < 3000 && !fin; cyc++) begin
            cfg_start = 1'b0;
            m_tready  = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
            mem_gnt   = (gmode == 0) ? 1'b1 : ((cyc % 4) == 2);
            #1;
            if (stalled && m_tvalid)
                chk(int'(m_tdata) == sdata, "R7 data held", int'(m_tdata), sdata);
            if (mem_req && mem_gnt)
                chk(int'(mem_addr) == (a + n) / 4, "R3 word address",
                    int'(mem_addr), (a + n) / 4);
            if (m_tvalid && m_tready) begin
                chk(m_tdata == mbyte(a + n), (n == 0) ? "R4 first lane" : "R5 byte order",
                    int'(m_tdata), int'(mbyte(a + n)));
                chk(m_tlast == (n == l - 1), "R6 tlast position", int'(m_tlast),
                    int'(n == l - 1));
                n++;
                if (n == l) fin = 1;
                if (poke && n == 1) cfg_start = 1'b1;
            end
            stalled = m_tvalid && !m_tready;
            sdata   = int'(m_tdata);
            @(negedge clk);
        end
        cfg_start = 1'b0;
        chk(n == l, "R6 beat count", n, l);
        chk(busy == 1'b0 && done == 1'b1, "R8 busy clear and done", int'({busy, done}), 1);
        @(negedge clk);
        chk(done == 1'b0 && m_tvalid == 1'b0, "R8 done one cycle / R9 no restart",
            int'({done, m_tvalid}), 0);
        m_tready = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cfg_start = 1'b0; cfg_addr = '0; cfg_len = '0;
        m_tready = 1'b1; mem_gnt = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, m_tvalid, mem_req} == 4'b0, "R1 reset state",
            int'({busy, done, m_tvalid, mem_req}), 0);
    endtask

    task automatic t_zero();
        @(negedge clk);
        cfg_addr = 16'h0042; cfg_len = 12'd0; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        chk(busy == 1'b0 && done == 1'b1, "R10 zero length done", int'({busy, done}), 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!m_tvalid && !mem_req && !done, "R10 nothing issued",
                int'({m_tvalid, mem_req, done}), 0);
        end
    endtask

    task automatic t_reqhold();
        // grant withheld: request must stay up, no bytes
        @(negedge clk);
        mem_gnt = 1'b0;
        cfg_addr = 16'h0011; cfg_len = 12'd2; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(mem_req && !m_tvalid && mem_addr == 14'h4, "R3 request held",
                int'({mem_req, m_tvalid}), 2);
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        chk(!mem_req && !m_tvalid, "R3 released after grant", int'({mem_req, m_tvalid}), 0);
        @(negedge clk);
        chk(m_tvalid && m_tdata == mbyte(16'h11), "R3 data one cycle after grant",
            int'(m_tdata), int'(mbyte(16'h11)));
        @(negedge clk);
        @(negedge clk);
        chk(!busy, "R8 idle after short frame", int'(busy), 0);
    endtask

    initial begin
        #1ms;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        run_xfer(16'h0040, 8, 0, 0, 0);   // aligned, free flow
        run_xfer(16'h0081, 6, 0, 0, 0);   // offset 1, crosses a word
        run_xfer(16'h0013, 1, 0, 0, 0);   // single byte in lane 3
        run_xfer(16'h0027, 5, 1, 1, 0);   // offset 3 with stalls
        run_xfer(16'h0052, 11, 1, 1, 0);  // offset 2, throttled both sides
        run_xfer(16'h0060, 4, 1, 0, 0);   // exactly one word
        run_xfer(16'h0005, 9, 1, 1, 1);   // start poked while busy
        t_zero();
        t_reqhold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule